// File: doc/BRIEF.md
# Atomic Channel Mask Set/Clear Register Front-End

The block holds two per-channel enable vectors for a 64-channel transfer engine. One is the hardware request enable mask. The other is the error interrupt enable mask. Software never writes either vector as a whole word. Instead it writes one byte to a set register or a clear register. That byte names one channel, or it asks for every channel at once. An update therefore needs no read-modify-write, and two agents cannot lose each other's changes.

The four write-only command bytes share one 32-bit word at byte offset 0x18. The byte lanes are big-endian:

| Byte offset | Data bits | Command |
|---|---|---|
| 0x18 | [31:24] | request set |
| 0x19 | [23:16] | request clear |
| 0x1A | [15:8] | error interrupt set |
| 0x1B | [7:0] | error interrupt clear |

A single word write with several byte enables can issue several commands in the same cycle. Both vectors are driven continuously on output ports. Each 32-bit half can also be read back over the same bus.

Top module: `cmask_regs`

## Requirements
- R1: After reset, both mask vectors are all zeroes, and every readback word returns zero.
- R2: In a command byte, bit 7 is reserved and bits [6:0] form the command field. A set command whose field bit 6 is 0 sets only the mask bit whose index is field bits [5:0]. The new value appears on the output ports and in readback in the cycle after the write edge.
- R3: A clear command whose field bit 6 is 0 clears only the mask bit whose index is field bits [5:0], starting in the next cycle.
- R4: A set command whose field bit 6 is 1 sets all 64 bits of its target mask. Field bits [5:0] are ignored in this case.
- R5: A clear command whose field bit 6 is 1 clears all 64 bits of its target mask. Field bits [5:0] are ignored in this case.
- R6: Bit 7 of a command byte has no effect. For example, 0x85 acts exactly like 0x05.
- R7: When a set and a clear reach the same bit of one mask in the same cycle, the bit ends up 0.
- R8: A read of word offset 0x18, which holds the command bytes, returns zero.
- R9: The mask halves read back at fixed word offsets:

  | Word offset | Contents |
  |---|---|
  | 0x08 | request mask, channels 63..32 |
  | 0x0C | request mask, channels 31..0 |
  | 0x10 | error mask, channels 63..32 |
  | 0x14 | error mask, channels 31..0 |

  In each word, bit n is the lowest channel of that half plus n.
- R10: Neither mask changes in three cases: a byte lane whose enable is low, a write to any address other than exactly 0x18, and a cycle with no command.
- R11: Commands on the request lanes never change the error mask, and commands on the error lanes never change the request mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 4 | Byte enables. Bit 3 enables data bits [31:24] (offset 0x18). |
| bus_addr | input | 8 | Byte address, shared by reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| req_en_mask | output | 64 | Request enable vector, bit n = channel n |
| err_int_en_mask | output | 64 | Error interrupt enable vector, bit n = channel n |

## Verification
A wrong decode of the channel index, a clear that loses to a set, or a stray lane enable each leaves a wrong bit in a mask. That bit shows on the mask ports in the cycle after the offending write edge. It also shows in the matching readback word as soon as that address is presented. Each command is followed by a comparison of both full vectors and all four readback words, so a corrupted bit in the other mask or the other half is caught in that same cycle. A reserved bit that leaked into the index would move the effect to another channel. A global command that also honoured the index bits would leave one bit unchanged. Both of these show up the same way, one cycle after the write.

// File: rtl/cmask_pkg.sv
package cmask_pkg;
  localparam int NUM_CH   = 64;
  localparam int CH_IDX_W = $clog2(NUM_CH);
  localparam int CMD_W    = CH_IDX_W + 1;
  localparam int LANES    = 4;

  typedef struct packed {
    logic                hit;
    logic                all;
    logic [CH_IDX_W-1:0] idx;
  } cmd_t;

  // lane 0 is the most significant byte (lowest byte address)
  function automatic logic [7:0] lane_byte(input logic [31:0] word, input int lane);
    logic [31:0] sh;
    sh = word >> (8 * (LANES - 1 - lane));
    return sh[7:0];
  endfunction

  function automatic cmd_t decode_cmd(input logic hit, input logic [7:0] b);
    cmd_t c;
    c.hit = hit;
    c.all = b[CMD_W-1];
    c.idx = b[CH_IDX_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/cmask_lane_dec.sv
module cmask_lane_dec
  import cmask_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic        ctrl_wr,
  input  logic        lane_en,
  input  logic [31:0] wdata,
  output cmd_t        cmd
);
  logic [7:0] cmd_byte;
  logic       unused_rsvd;

  assign cmd_byte    = lane_byte(wdata, LANE);
  assign unused_rsvd = cmd_byte[7];
  assign cmd         = decode_cmd(ctrl_wr & lane_en, cmd_byte);
endmodule

// File: rtl/cmask_vec.sv
module cmask_vec
  import cmask_pkg::*;
#(
  parameter int CHANNELS = NUM_CH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  cmd_t                set_cmd,
  input  cmd_t                clr_cmd,
  output logic [CHANNELS-1:0] q
);
  logic [CHANNELS-1:0] set_vec;
  logic [CHANNELS-1:0] clr_vec;
  logic                any_cmd;

  for (genvar i = 0; i < CHANNELS; i++) begin : g_bit
    assign set_vec[i] = set_cmd.hit & (set_cmd.all | (set_cmd.idx == CH_IDX_W'(i)));
    assign clr_vec[i] = clr_cmd.hit & (clr_cmd.all | (clr_cmd.idx == CH_IDX_W'(i)));
  end

  assign any_cmd = set_cmd.hit | clr_cmd.hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q | set_vec) & ~clr_vec;
  end

  assert_single_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd.hit |=> !q[$past(clr_cmd.idx)]);
  assert_global_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd.hit && clr_cmd.all) |=> (q == '0));
  assert_global_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cmd.hit && set_cmd.all && !clr_cmd.hit) |=> (&q));
  assert_single_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cmd.hit && !clr_cmd.hit) |=> q[$past(set_cmd.idx)]);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_cmd |=> $stable(q));
endmodule

// File: rtl/cmask_rdmux.sv
module cmask_rdmux #(
  parameter int CHANNELS = 64,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int REQ_BASE = 8,
  parameter int ERR_BASE = 16
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CHANNELS-1:0] req_q,
  input  logic [CHANNELS-1:0] err_q,
  output logic [DATA_W-1:0]   rdata
);
  localparam int NUM_WORDS = CHANNELS / DATA_W;
  localparam int WORD_B    = DATA_W / 8;

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (addr == ADDR_W'(REQ_BASE + WORD_B * k))
        rdata = req_q[(NUM_WORDS-1-k)*DATA_W +: DATA_W];
      if (addr == ADDR_W'(ERR_BASE + WORD_B * k))
        rdata = err_q[(NUM_WORDS-1-k)*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/cmask_regs.sv
module cmask_regs
  import cmask_pkg::*;
#(
  parameter int CHANNELS  = NUM_CH,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int REQ_BASE  = 8,
  parameter int ERR_BASE  = 16,
  parameter int CTRL_BASE = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [3:0]          bus_be,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [CHANNELS-1:0] req_en_mask,
  output logic [CHANNELS-1:0] err_int_en_mask
);
  localparam int LANE_REQ_SET = 0;
  localparam int LANE_REQ_CLR = 1;
  localparam int LANE_ERR_SET = 2;
  localparam int LANE_ERR_CLR = 3;

  logic ctrl_wr;
  cmd_t lane_cmd [LANES];

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_BASE));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    cmask_lane_dec #(.LANE(l)) u_dec (
      .ctrl_wr (ctrl_wr),
      .lane_en (bus_be[LANES-1-l]),
      .wdata   (bus_wdata),
      .cmd     (lane_cmd[l])
    );
  end

  cmask_vec #(.CHANNELS(CHANNELS)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_cmd (lane_cmd[LANE_REQ_SET]),
    .clr_cmd (lane_cmd[LANE_REQ_CLR]),
    .q       (req_en_mask)
  );

  cmask_vec #(.CHANNELS(CHANNELS)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_cmd (lane_cmd[LANE_ERR_SET]),
    .clr_cmd (lane_cmd[LANE_ERR_CLR]),
    .q       (err_int_en_mask)
  );

  cmask_rdmux #(
    .CHANNELS (CHANNELS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .REQ_BASE (REQ_BASE),
    .ERR_BASE (ERR_BASE)
  ) u_rd (
    .addr  (bus_addr),
    .req_q (req_en_mask),
    .err_q (err_int_en_mask),
    .rdata (bus_rdata)
  );

  assert_ctrl_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(CTRL_BASE)) |-> (bus_rdata == '0));
  assert_req_low_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(REQ_BASE + DATA_W/8)) |-> (bus_rdata == req_en_mask[DATA_W-1:0]));
  assert_err_isolated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!lane_cmd[LANE_ERR_SET].hit && !lane_cmd[LANE_ERR_CLR].hit) |=> $stable(err_int_en_mask));
  assert_no_stray_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> ($stable(req_en_mask) && $stable(err_int_en_mask)));
endmodule

// File: tb/test_cmask_regs.sv
module test_cmask_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] req_en_mask;
  logic [63:0] err_int_en_mask;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cmask_regs i_cmask_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_en_mask(req_en_mask), .err_int_en_mask(err_int_en_mask)
  );

  // {be, wdata, expected request mask, expected error mask}
  localparam int NV = 12;
  localparam logic [163:0] VEC [NV] = '{
    {4'b1000, 32'h05000000, 64'h0000000000000020, 64'h0000000000000000},
    {4'b1000, 32'h28000000, 64'h0000010000000020, 64'h0000000000000000},
    {4'b0010, 32'h00004000, 64'h0000010000000020, 64'hFFFFFFFFFFFFFFFF},
    {4'b0001, 32'h0000003F, 64'h0000010000000020, 64'h7FFFFFFFFFFFFFFF},
    {4'b0100, 32'h00050000, 64'h0000010000000000, 64'h7FFFFFFFFFFFFFFF},
    {4'b1111, 32'h4040007F, 64'h0000000000000000, 64'h0000000000000000},
    {4'b1000, 32'h85000000, 64'h0000000000000020, 64'h0000000000000000},
    {4'b0010, 32'h0000C000, 64'h0000000000000020, 64'hFFFFFFFFFFFFFFFF},
    {4'b0000, 32'h00410000, 64'h0000000000000020, 64'hFFFFFFFFFFFFFFFF},
    {4'b1111, 32'h1F201F00, 64'h0000000080000020, 64'hFFFFFFFFFFFFFFFE},
    {4'b0100, 32'h00C00000, 64'h0000000000000000, 64'hFFFFFFFFFFFFFFFE},
    {4'b1100, 32'h07070000, 64'h0000000000000000, 64'hFFFFFFFFFFFFFFFE}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1:    return "R2";
      2:       return "R4";
      3, 4:    return "R3";
      5:       return "R7";
      6, 7:    return "R6";
      8:       return "R10";
      9:       return "R11";
      10:      return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic check_state(input string tag, input logic [63:0] er, input logic [63:0] ee);
    logic [31:0] d;
    chk(tag, "req_en_mask", req_en_mask, er);
    chk(tag, "err_int_en_mask", err_int_en_mask, ee);
    rd(8'h08, d); chk("R9", "rd 0x08", {32'h0, d}, {32'h0, er[63:32]});
    rd(8'h0C, d); chk("R9", "rd 0x0C", {32'h0, d}, {32'h0, er[31:0]});
    rd(8'h10, d); chk("R9", "rd 0x10", {32'h0, d}, {32'h0, ee[63:32]});
    rd(8'h14, d); chk("R9", "rd 0x14", {32'h0, d}, {32'h0, ee[31:0]});
  endtask

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1", 64'h0, 64'h0);

    for (int i = 0; i < NV; i++) begin
      do_write(8'h18, VEC[i][163:160], VEC[i][159:128]);
      check_state(tag_of(i), VEC[i][127:64], VEC[i][63:0]);
    end

    // R8: command word reads zero even while masks are non-zero
    rd(8'h18, d); chk("R8", "rd 0x18", {32'h0, d}, 64'h0);

    // R10: writes to readback word and to a misaligned address change nothing
    do_write(8'h0C, 4'hF, 32'h05050505);
    check_state("R10", 64'h0, 64'hFFFFFFFFFFFFFFFE);
    do_write(8'h19, 4'hF, 32'h40404040);
    check_state("R10", 64'h0, 64'hFFFFFFFFFFFFFFFE);

    // R2: highest channel
    do_write(8'h18, 4'h8, 32'h3F000000);
    check_state("R2", 64'h8000000000000000, 64'hFFFFFFFFFFFFFFFE);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_state("R1", 64'h0, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1", 64'h0, 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule